// File: doc/BRIEF.md
# Hex Record Command Parser

This block sits behind a UART receiver and turns a stream of ASCII characters into loader commands. It waits for a colon, then reads hex-digit pairs that make up these fields in order: a byte count, a two-byte address, a record type, the data bytes, and a closing checksum. Each decoded byte is added to a running 8-bit sum. Data bytes are held in a small buffer. Nothing is executed until the checksum byte has arrived and the sum has been checked.

Three record types are recognised:
- Type 00 writes its data bytes into a memory model, one byte per cycle. The memory reports whether each write verified.
- Type 01 marks the end of the file and does nothing.
- Type 02 loads an oscillator-frequency register, in whole MHz. A type 00 record is refused until this register has been loaded.

Each record that reaches a verdict is answered with one character on a byte-out stream:
- '.' means success.
- 'X' means a checksum error or a malformed character.
- 'R' means a refused command or a write that failed to verify.

Top module: `hexrec_parser`

## Requirements
- R1: While no record is open, every received character other than ':' (0x3A) is accepted and dropped, and no reply is sent.
- R2: After ':', characters are read as hex-digit pairs, high nibble first. Digits 0-9, A-F and a-f are all valid. The decoded bytes are, in order: count, address high, address low, type, count data bytes, checksum.
- R3: A count above 16, or a type other than 0x00, 0x01 or 0x02, silently abandons the record. The block then hunts for the next ':'.
- R4: A character inside an open record that is not a hex digit (':' included) abandons the record and produces the reply 'X' (0x58).
- R5: A complete record whose decoded bytes, checksum included, do not add to zero modulo 256 gets the reply 'X' and has no other effect.
- R6: A type 0x01 record with a good checksum gets the reply '.' (0x2E). It causes no memory write, whatever its address field holds.
- R7: A type 0x02 record with count 1 and a good checksum loads its data byte into the frequency output, sets the frequency-valid flag and gets '.'. With any other count it gets 'R' (0x52) and leaves both outputs unchanged.
- R8: A type 0x00 record with a good checksum, received while the frequency-valid flag is clear, gets 'R' and performs no write.
- R9: Otherwise a type 0x00 record writes data byte i to address (address field + i) mod 65536, in order, one per cycle. Every remaining byte is still written after a failure. The reply is 'R' if any write reported a verify failure, and '.' otherwise, which includes a count of 0.
- R10: Input ready is low from the cycle after a record's last character until its reply has been taken. Each record produces at most one reply, and that reply is held stable while output ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 8 | Received character |
| rx_valid | input | 1 | rx_data holds a character |
| rx_ready | output | 1 | Block accepts the character this cycle |
| tx_data | output | 8 | Reply character |
| tx_valid | output | 1 | Reply pending |
| tx_ready | input | 1 | Consumer takes the reply this cycle |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | 16 | Memory write address |
| mem_wr_data | output | 8 | Memory write data |
| mem_wr_ok | input | 1 | Verify result for the write in the same cycle |
| osc_mhz | output | 8 | Oscillator frequency in whole MHz |
| osc_valid | output | 1 | Frequency register has been loaded |

## Verification
Directed records cover the cases that separate the reply codes:
- a bad checksum against a failed write;
- a write refused before any frequency record against one accepted after it;
- an oversize count or unknown type, which must stay silent, against a stray non-hex character, which must answer 'X'.

Mixed-case digits, a 16-byte write that wraps past address 0xFFFF, a zero-length write and a stalled reply consumer check digit decoding, address arithmetic and reply holding. A seeded random stream of well-formed and corrupted records of all three types is then compared against a bench model of the expected reply, memory contents and frequency register.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

  localparam logic [7:0] CH_COLON = 8'h3A;
  localparam logic [7:0] CH_OK    = 8'h2E;
  localparam logic [7:0] CH_BAD   = 8'h58;
  localparam logic [7:0] CH_REFUSE = 8'h52;

  localparam logic [7:0] RT_DATA = 8'h00;
  localparam logic [7:0] RT_EOF  = 8'h01;
  localparam logic [7:0] RT_OSC  = 8'h02;

  typedef enum logic [1:0] {X_IDLE, X_WRITE, X_REPLY} exec_state_t;

  function automatic logic is_hex(input logic [7:0] c);
    return (c >= 8'h30 && c <= 8'h39) || (c >= 8'h41 && c <= 8'h46) ||
           (c >= 8'h61 && c <= 8'h66);
  endfunction

  function automatic logic [3:0] hex_val(input logic [7:0] c);
    logic [7:0] v;
    if (c <= 8'h39)      v = c - 8'h30;
    else if (c <= 8'h46) v = c - 8'h37;
    else                 v = c - 8'h57;
    return v[3:0];
  endfunction

endpackage

// File: rtl/hexrec_rx.sv
module hexrec_rx import hexrec_pkg::*; #(
  parameter int MAX_DATA = 16,
  localparam int BUFW = $clog2(MAX_DATA)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_fire,
  input  logic [7:0]      in_byte,
  input  logic [BUFW-1:0] rd_idx,
  output logic [7:0]      rd_data,
  output logic            done_o,
  output logic            bad_o,
  output logic            sum_ok_o,
  output logic [7:0]      cnt_o,
  output logic [15:0]     addr_o,
  output logic [7:0]      type_o
);

  logic        open_q, open_d;
  logic        hi_q, hi_d;
  logic [3:0]  nib_q, nib_d;
  logic [7:0]  idx_q, idx_d;
  logic [7:0]  sum_q, sum_d;
  logic [7:0]  cnt_q, cnt_d;
  logic [15:0] addr_q, addr_d;
  logic [7:0]  type_q, type_d;
  logic        done_q, done_d, bad_q, bad_d, sok_q, sok_d;
  logic        buf_we;
  logic [7:0]  buf_q [MAX_DATA];

  logic [7:0]  byte_v, sum_nx, off;
  logic        is_last;

  assign byte_v  = {nib_q, hex_val(in_byte)};
  assign sum_nx  = sum_q + byte_v;
  assign off     = idx_q - 8'd4;
  assign is_last = (idx_q >= 8'd4) && (idx_q == cnt_q + 8'd4);

  always_comb begin
    open_d = open_q; hi_d = hi_q; nib_d = nib_q; idx_d = idx_q;
    sum_d = sum_q; cnt_d = cnt_q; addr_d = addr_q; type_d = type_q;
    sok_d = sok_q; done_d = 1'b0; bad_d = 1'b0; buf_we = 1'b0;
    if (in_fire) begin
      if (!open_q) begin
        if (in_byte == CH_COLON) begin
          open_d = 1'b1; hi_d = 1'b0; idx_d = 8'd0; sum_d = 8'd0;
        end
      end else if (!is_hex(in_byte)) begin
        bad_d  = 1'b1;
        open_d = 1'b0;
      end else if (!hi_q) begin
        hi_d  = 1'b1;
        nib_d = hex_val(in_byte);
      end else begin
        hi_d  = 1'b0;
        sum_d = sum_nx;
        idx_d = idx_q + 8'd1;
        case (idx_q)
          8'd0: begin
            cnt_d = byte_v;
            if (byte_v > 8'(MAX_DATA)) open_d = 1'b0;
          end
          8'd1: addr_d[15:8] = byte_v;
          8'd2: addr_d[7:0]  = byte_v;
          8'd3: begin
            type_d = byte_v;
            if (byte_v > RT_OSC) open_d = 1'b0;
          end
          default: begin
            if (is_last) begin
              done_d = 1'b1;
              open_d = 1'b0;
              sok_d  = (sum_nx == 8'd0);
            end else begin
              buf_we = 1'b1;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0; hi_q <= 1'b0; nib_q <= '0; idx_q <= '0;
      sum_q <= '0; cnt_q <= '0; addr_q <= '0; type_q <= '0;
      done_q <= 1'b0; bad_q <= 1'b0; sok_q <= 1'b0;
    end else begin
      open_q <= open_d; hi_q <= hi_d; nib_q <= nib_d; idx_q <= idx_d;
      sum_q <= sum_d; cnt_q <= cnt_d; addr_q <= addr_d; type_q <= type_d;
      done_q <= done_d; bad_q <= bad_d; sok_q <= sok_d;
    end
  end

  for (genvar g = 0; g < MAX_DATA; g++) begin : g_buf
    always_ff @(posedge clk) begin
      if (buf_we && off[BUFW-1:0] == BUFW'(g)) buf_q[g] <= byte_v;
    end
  end

  assign rd_data  = buf_q[rd_idx];
  assign done_o   = done_q;
  assign bad_o    = bad_q;
  assign sum_ok_o = sok_q;
  assign cnt_o    = cnt_q;
  assign addr_o   = addr_q;
  assign type_o   = type_q;

  // R3: a completed record never carries an oversize count or unknown type
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cnt_q <= 8'(MAX_DATA)));
  a_r3_type_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (type_q <= RT_OSC));
  // R4: a completion and a bad-character abort never coincide
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && bad_q));

endmodule

// File: rtl/hexrec_exec.sv
module hexrec_exec import hexrec_pkg::*; #(
  parameter int MAX_DATA = 16,
  localparam int BUFW = $clog2(MAX_DATA),
  localparam int WIW  = BUFW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            done_i,
  input  logic            bad_i,
  input  logic            sum_ok_i,
  input  logic [7:0]      cnt_i,
  input  logic [15:0]     addr_i,
  input  logic [7:0]      type_i,
  input  logic [7:0]      rd_data_i,
  output logic [BUFW-1:0] rd_idx_o,
  output logic            busy_o,
  output logic [7:0]      tx_data,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic            mem_wr_en,
  output logic [15:0]     mem_wr_addr,
  output logic [7:0]      mem_wr_data,
  input  logic            mem_wr_ok,
  output logic [7:0]      osc_mhz,
  output logic            osc_valid
);

  exec_state_t    st_q, st_d;
  logic [WIW-1:0] wi_q, wi_d;
  logic           fail_q, fail_d, fail_nx;
  logic [7:0]     rep_q, rep_d;
  logic [7:0]     osc_q, osc_d;
  logic           oscv_q, oscv_d;

  assign mem_wr_en   = (st_q == X_WRITE);
  assign mem_wr_addr = addr_i + 16'(wi_q);
  assign mem_wr_data = rd_data_i;
  assign rd_idx_o    = wi_q[BUFW-1:0];
  assign fail_nx     = fail_q | ~mem_wr_ok;

  always_comb begin
    st_d = st_q; wi_d = wi_q; fail_d = fail_q; rep_d = rep_q;
    osc_d = osc_q; oscv_d = oscv_q;
    case (st_q)
      X_IDLE: begin
        if (bad_i) begin
          rep_d = CH_BAD; st_d = X_REPLY;
        end else if (done_i) begin
          st_d = X_REPLY;
          if (!sum_ok_i) rep_d = CH_BAD;
          else if (type_i == RT_EOF) rep_d = CH_OK;
          else if (type_i == RT_OSC) begin
            if (cnt_i == 8'd1) begin
              osc_d = rd_data_i; oscv_d = 1'b1; rep_d = CH_OK;
            end else rep_d = CH_REFUSE;
          end else if (!oscv_q) rep_d = CH_REFUSE;
          else if (cnt_i == 8'd0) rep_d = CH_OK;
          else begin
            st_d = X_WRITE; wi_d = '0; fail_d = 1'b0;
          end
        end
      end
      X_WRITE: begin
        fail_d = fail_nx;
        if (8'(wi_q) == cnt_i - 8'd1) begin
          wi_d  = '0;
          st_d  = X_REPLY;
          rep_d = fail_nx ? CH_REFUSE : CH_OK;
        end else begin
          wi_d = wi_q + WIW'(1);
        end
      end
      X_REPLY: if (tx_ready) st_d = X_IDLE;
      default: st_d = X_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= X_IDLE; wi_q <= '0; fail_q <= 1'b0; rep_q <= CH_OK;
      osc_q <= '0; oscv_q <= 1'b0;
    end else begin
      st_q <= st_d; wi_q <= wi_d; fail_q <= fail_d; rep_q <= rep_d;
      osc_q <= osc_d; oscv_q <= oscv_d;
    end
  end

  assign busy_o    = (st_q != X_IDLE);
  assign tx_valid  = (st_q == X_REPLY);
  assign tx_data   = rep_q;
  assign osc_mhz   = osc_q;
  assign osc_valid = oscv_q;

  // R8: no memory write before the frequency register is loaded
  a_r8_no_write_before_osc: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> osc_valid);
  // R10: a pending reply stays put until taken
  a_r10_reply_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R5: a completed record with a bad sum answers 'X' next cycle
  a_r5_bad_sum_x: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == X_IDLE && done_i && !sum_ok_i) |=> (tx_valid && tx_data == CH_BAD));
  // R4: a bad character answers 'X' next cycle
  a_r4_bad_char_x: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == X_IDLE && bad_i) |=> (tx_valid && tx_data == CH_BAD));
  // R7: the frequency register only changes on leaving idle
  a_r7_osc_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != X_IDLE) |=> $stable(osc_mhz));

endmodule

// File: rtl/hexrec_parser.sv
module hexrec_parser #(
  parameter int MAX_DATA = 16,
  localparam int BUFW = $clog2(MAX_DATA)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic        mem_wr_en,
  output logic [15:0] mem_wr_addr,
  output logic [7:0]  mem_wr_data,
  input  logic        mem_wr_ok,
  output logic [7:0]  osc_mhz,
  output logic        osc_valid
);

  logic            done, bad, sum_ok, busy;
  logic [7:0]      cnt, rtype, rd_data;
  logic [15:0]     addr;
  logic [BUFW-1:0] rd_idx;

  assign rx_ready = !busy && !done && !bad;

  hexrec_rx #(.MAX_DATA(MAX_DATA)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .in_fire(rx_valid && rx_ready), .in_byte(rx_data),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .done_o(done), .bad_o(bad), .sum_ok_o(sum_ok),
    .cnt_o(cnt), .addr_o(addr), .type_o(rtype)
  );

  hexrec_exec #(.MAX_DATA(MAX_DATA)) u_exec (
    .clk(clk), .rst_n(rst_n),
    .done_i(done), .bad_i(bad), .sum_ok_i(sum_ok),
    .cnt_i(cnt), .addr_i(addr), .type_i(rtype), .rd_data_i(rd_data),
    .rd_idx_o(rd_idx), .busy_o(busy),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ok(mem_wr_ok),
    .osc_mhz(osc_mhz), .osc_valid(osc_valid)
  );

  // R10: no input taken while a command or reply is in progress
  a_r10_no_rx_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rx_ready);
  // R10: a reply and a memory write never overlap
  a_r10_reply_after_writes: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && mem_wr_en));

endmodule

// File: tb/hexrec_parser_bench.sv
module hexrec_parser_bench;
  localparam int CLK_PERIOD = 10;
  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_valid = 1'b0, tx_ready = 1'b1;
  logic rx_ready, tx_valid, mem_wr_en, mem_wr_ok, osc_valid;
  logic [7:0] tx_data, mem_wr_data, osc_mhz;
  logic [15:0] mem_wr_addr;

  int n_chk = 0, n_bad = 0, rep_cnt = 0, wr_cnt = 0;
  logic [7:0] last_rep = 8'h00;
  logic [7:0] mem [int];
  logic fail_en = 1'b0;
  logic [15:0] fail_addr = 16'h0;
  logic osc_m = 1'b0;
  logic [7:0] oscv_m = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  hexrec_parser u_hexrec_parser (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ok(mem_wr_ok), .osc_mhz(osc_mhz),
    .osc_valid(osc_valid)
  );

  assign mem_wr_ok = !(fail_en && mem_wr_addr == fail_addr);

  always @(posedge clk) if (mem_wr_en) begin
    wr_cnt++;
    if (mem_wr_ok) mem[int'(mem_wr_addr)] = mem_wr_data;
  end

  always @(negedge clk) if (tx_valid && tx_ready) begin
    rep_cnt++;
    last_rep = tx_data;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hexch(input logic [3:0] n, input bit lower);
    if (n < 4'd10) return 8'h30 + 8'(n);
    return (lower ? 8'h61 : 8'h41) + 8'(n) - 8'd10;
  endfunction

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_data = b; rx_valid = 1'b1;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_byte(s[i]);
  endtask

  task automatic send_rec(input logic [15:0] addr, input logic [7:0] typ,
                          input bq_t d, input bit corrupt, input bit lower);
    bq_t b;
    logic [7:0] s;
    b.push_back(8'(d.size())); b.push_back(addr[15:8]); b.push_back(addr[7:0]);
    b.push_back(typ);
    foreach (d[i]) b.push_back(d[i]);
    s = 8'h00;
    foreach (b[i]) s += b[i];
    b.push_back((8'h00 - s) ^ (corrupt ? 8'h01 : 8'h00));
    send_byte(8'h3A);
    foreach (b[i]) begin
      send_byte(hexch(b[i][7:4], lower));
      send_byte(hexch(b[i][3:0], lower));
    end
  endtask

  task automatic wait_reply(input int start, output logic [7:0] r);
    r = 8'h00;
    for (int i = 0; i < 200; i++) begin
      if (rep_cnt != start) begin r = last_rep; break; end
      @(negedge clk);
    end
  endtask

  task automatic do_rec(input logic [15:0] addr, input logic [7:0] typ, input bq_t d,
                        input bit corrupt, input bit lower, input logic [7:0] exp,
                        input string req);
    int st;
    logic [7:0] r;
    st = rep_cnt;
    send_rec(addr, typ, d, corrupt, lower);
    wait_reply(st, r);
    chk(r == exp, req, r, exp);
  endtask

  task automatic chk_silent(input int start, input string req);
    repeat (40) @(negedge clk);
    chk(rep_cnt == start, req, rep_cnt - start, 0);
  endtask

  task automatic chk_mem(input logic [15:0] addr, input bq_t d, input string req);
    bit ok = 1'b1;
    foreach (d[i]) begin
      int a = int'(16'(addr + 16'(i)));
      if (!mem.exists(a) || mem[a] != d[i]) ok = 1'b0;
    end
    chk(ok, req, ok, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int st, w0;
    bq_t d;
    logic [7:0] r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_ready == 1'b1, "R10 reset rx_ready", rx_ready, 1);
    chk(tx_valid == 1'b0, "R10 reset tx_valid", tx_valid, 0);
    chk(osc_valid == 1'b0, "R7 reset osc_valid", osc_valid, 0);
    chk(mem_wr_en == 1'b0, "R9 reset mem_wr_en", mem_wr_en, 0);

    // R1: noise outside a record
    st = rep_cnt;
    send_str("ab\nZ09");
    chk_silent(st, "R1 noise ignored");
    do_rec(16'hBEEF, 8'h01, '{}, 1'b0, 1'b0, 8'h2E, "R6 eof after noise");

    // R8: write before frequency
    w0 = wr_cnt;
    do_rec(16'h1234, 8'h00, '{8'h11, 8'h22}, 1'b0, 1'b0, 8'h52, "R8 refuse before osc");
    chk(wr_cnt == w0, "R8 no write", wr_cnt - w0, 0);

    // R7: frequency record with wrong count, then correct one
    do_rec(16'h0000, 8'h02, '{8'h10, 8'h20}, 1'b0, 1'b0, 8'h52, "R7 count 2 refused");
    chk(osc_valid == 1'b0, "R7 osc unchanged", osc_valid, 0);
    do_rec(16'h0000, 8'h02, '{8'h10}, 1'b0, 1'b0, 8'h2E, "R7 osc accepted");
    chk(osc_valid && osc_mhz == 8'h10, "R7 osc value", osc_mhz, 8'h10);
    osc_m = 1'b1; oscv_m = 8'h10;

    // R6: eof does no write
    w0 = wr_cnt;
    do_rec(16'h4321, 8'h01, '{}, 1'b0, 1'b1, 8'h2E, "R6 eof ok");
    chk(wr_cnt == w0, "R6 eof no write", wr_cnt - w0, 0);

    // R5: bad checksum
    w0 = wr_cnt;
    do_rec(16'h2000, 8'h00, '{8'hAA, 8'h55, 8'h01}, 1'b1, 1'b0, 8'h58, "R5 bad sum");
    chk(wr_cnt == w0, "R5 no write", wr_cnt - w0, 0);

    // R3: oversize count and unknown type are silent
    st = rep_cnt;
    send_str(":11000000");
    chk_silent(st, "R3 count 17 silent");
    send_str(":00000003FD");
    chk_silent(st, "R3 type 03 silent");
    do_rec(16'h0000, 8'h01, '{}, 1'b0, 1'b0, 8'h2E, "R3 resync after abort");

    // R4: non-hex character inside a record
    st = rep_cnt;
    send_str(":0100G");
    wait_reply(st, r);
    chk(r == 8'h58, "R4 bad char X", r, 8'h58);
    st = rep_cnt;
    send_str(":01:");
    wait_reply(st, r);
    chk(r == 8'h58, "R4 colon inside X", r, 8'h58);

    // R2: lower-case digits
    d = '{8'hAB, 8'hCD, 8'hEF};
    do_rec(16'h3A5F, 8'h00, d, 1'b0, 1'b1, 8'h2E, "R2 lower case");
    chk_mem(16'h3A5F, d, "R2 lower case data");

    // R9: 16 bytes wrapping past 0xFFFF
    d = {};
    for (int i = 0; i < 16; i++) d.push_back(8'(i * 17 + 3));
    do_rec(16'hFFF8, 8'h00, d, 1'b0, 1'b0, 8'h2E, "R9 wrap write");
    chk_mem(16'hFFF8, d, "R9 wrap data");

    // R9: verify failure mid-record, later bytes still written
    fail_en = 1'b1; fail_addr = 16'h5001;
    d = '{8'h01, 8'h02, 8'h03, 8'h04};
    w0 = wr_cnt;
    do_rec(16'h5000, 8'h00, d, 1'b0, 1'b0, 8'h52, "R9 verify fail R");
    chk(wr_cnt - w0 == 4, "R9 all bytes attempted", wr_cnt - w0, 4);
    chk(mem.exists(32'h5003) && mem[32'h5003] == 8'h04, "R9 byte after failure",
        mem.exists(32'h5003) ? mem[32'h5003] : 0, 4);
    fail_en = 1'b0;

    // R9: zero-length write
    w0 = wr_cnt;
    do_rec(16'h6000, 8'h00, '{}, 1'b0, 1'b0, 8'h2E, "R9 zero count");
    chk(wr_cnt == w0, "R9 zero count no write", wr_cnt - w0, 0);

    // R10: stalled reply consumer
    tx_ready = 1'b0;
    st = rep_cnt;
    send_rec(16'h0000, 8'h01, '{}, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    chk(tx_valid && tx_data == 8'h2E, "R10 reply held", tx_data, 8'h2E);
    chk(rx_ready == 1'b0, "R10 rx blocked", rx_ready, 0);
    tx_ready = 1'b1;
    wait_reply(st, r);
    @(negedge clk);
    chk(rep_cnt - st == 1, "R10 one reply", rep_cnt - st, 1);

    // random records against the bench model
    for (int k = 0; k < 60; k++) begin
      int t = $urandom_range(0, 5);
      bit bad = ($urandom_range(0, 5) == 0);
      bit lc = $urandom_range(0, 1);
      logic [15:0] a = 16'($urandom);
      logic [7:0] typ, exp;
      d = {};
      if (t == 0) typ = 8'h01;
      else if (t == 1) begin typ = 8'h02; d.push_back(8'($urandom_range(1, 40))); end
      else begin
        typ = 8'h00;
        for (int i = 0; i < $urandom_range(0, 16); i++) d.push_back(8'($urandom));
      end
      if (bad) exp = 8'h58;
      else if (typ == 8'h00 && !osc_m) exp = 8'h52;
      else exp = 8'h2E;
      do_rec(a, typ, d, bad, lc, exp, "R9 random reply");
      if (!bad && typ == 8'h02) oscv_m = d[0];
      if (!bad && typ == 8'h00) chk_mem(a, d, "R9 random data");
      chk(osc_mhz == oscv_m, "R7 random osc", osc_mhz, oscv_m);
    end

    summary();
    $finish;
  end
endmodule